// File: doc/BRIEF.md
# PCI Interrupt Router and Conditioner

This block takes a pin-level change from any PCI device slot and maps the pair of slot and interrupt pin onto an internal interrupt line number. The wiring between slots and lines is fixed by the board. Line numbers start at 32. The on-board south-bridge slot spreads its four pins across the first four lines. Two other on-board slots each own one line. A group of expansion slots shares a rotating window of lines. Any slot that is not in the table keeps its raw pin number.

The block then conditions the request it sends to the CPU interrupt controller. It uses two configuration vectors from the register file, an edge-select vector and a polarity vector. The line's bit index into these vectors is (line − 32) modulo 32.

- When the edge bit is set, the request is a single-cycle pulse. The pulse fires only on a rising edge of that source's pin level.
- Otherwise the request is held at the value of the polarity bit until the next update.

Every update is a one-cycle strobe carrying the slot, the pin and the new level. The mapped line and the conditioned request both appear in the cycle after the strobe.

Top module: `irq_router`

## Requirements
- R1: After reset, `line_o` is 0 and `irq_req_o` is 0.
- R2: An update from slot 5 with pin p gives `line_o` = 32 + (p mod 4).
- R3: An update from slot 6 gives `line_o` = 36 for every pin. An update from slot 7 gives `line_o` = 37 for every pin.
- R4: An update from slots 8 to 12 with pin p gives `line_o` = 38 + (slot − 8) + p.
- R5: An update from any slot other than 5 to 12 gives `line_o` = p, the pin number untranslated.
- R6: `line_o` changes only in the cycle after `evt_valid_i` is high, and it holds its value otherwise.
- R7: If the edge bit is set and the update is a rising edge (previous level of that slot/pin 0, new level 1), `irq_req_o` is high for exactly one cycle after the strobe. It is low in the next cycle unless another update arrives.
- R8: If the edge bit is set and the update is not a rising edge, no pulse is produced. After any edge-mode update, `irq_req_o` stays low until the next update.
- R9: If the edge bit is clear, `irq_req_o` after the update equals the polarity bit of the line. The output holds that value until the next update, even when the vectors change.
- R10: The edge and polarity bits are selected at index (line − 32) mod 32. For example, an untranslated line 3 uses bit 3, and line 45 uses bit 13.
- R11: The previous level is tracked separately for each slot/pin source, and all sources clear to 0 at reset. The first high update after reset is therefore a rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_valid_i | input | 1 | One-cycle strobe for a pin-level update |
| evt_slot_i | input | 5 | Slot number of the updating device |
| evt_pin_i | input | 2 | Interrupt pin index (0 to 3) |
| evt_level_i | input | 1 | New level of that pin |
| edge_sel_i | input | 32 | Edge-select bit per line index |
| pol_sel_i | input | 32 | Polarity bit per line index |
| line_o | output | 8 | Mapped internal line number of the last update |
| irq_req_o | output | 1 | Conditioned request to the interrupt controller |

## Verification
The bound checker checks the following on every cycle:
- `line_o` is stable when no update arrives.
- The fixed mappings of slots 5, 6 and 7 are correct.
- The request after a level-mode update follows the polarity bit selected through the mapped line.
- Edge pulses last exactly one cycle.
- A falling or steady update never pulses.

The bench scenarios are needed for the following:
- The full swizzle table over every slot and pin.
- The per-source memory of previous levels across interleaved sources.
- The behaviour that follows reset.
- The request holding its value while the vectors are rewritten between updates.

// File: rtl/irq_router_pkg.sv
package irq_router_pkg;
   // Board-fixed slot assignments
   localparam int SOUTH_SLOT    = 5;
   localparam int VIDEO_SLOT    = 6;
   localparam int NET_SLOT      = 7;
   localparam int EXP_FIRST     = 8;
   localparam int EXP_LAST      = 12;
   // Offsets from the line base
   localparam int VIDEO_OFS     = 4;
   localparam int NET_OFS       = 5;
   localparam int EXP_OFS       = 6;
endpackage

// File: rtl/irq_swizzle.sv
module irq_swizzle
   import irq_router_pkg::*;
#(
   parameter int SLOT_W    = 5,
   parameter int PIN_W     = 2,
   parameter int LINE_W    = 8,
   parameter int LINE_BASE = 32
) (
   input  logic [SLOT_W-1:0] slot_i,
   input  logic [PIN_W-1:0]  pin_i,
   output logic [LINE_W-1:0] line_o
);
   localparam logic [LINE_W-1:0] BASE_L = LINE_W'(LINE_BASE);

   logic [LINE_W-1:0] pin_l;
   logic [LINE_W-1:0] slot_l;

   assign pin_l  = LINE_W'(pin_i);
   assign slot_l = LINE_W'(slot_i);

   always_comb begin
      if (slot_i == SLOT_W'(SOUTH_SLOT))
         line_o = BASE_L + LINE_W'(pin_i[1:0]);
      else if (slot_i == SLOT_W'(VIDEO_SLOT))
         line_o = BASE_L + LINE_W'(VIDEO_OFS);
      else if (slot_i == SLOT_W'(NET_SLOT))
         line_o = BASE_L + LINE_W'(NET_OFS);
      else if (slot_i >= SLOT_W'(EXP_FIRST) && slot_i <= SLOT_W'(EXP_LAST))
         line_o = BASE_L + LINE_W'(EXP_OFS) + (slot_l - LINE_W'(EXP_FIRST)) + pin_l;
      else
         line_o = pin_l;
   end
endmodule

// File: rtl/irq_edge_track.sv
module irq_edge_track #(
   parameter int SRC_W = 7,
   localparam int NSRC = 1 << SRC_W
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             upd_i,
   input  logic [SRC_W-1:0] src_i,
   input  logic             level_i,
   output logic             rise_o
);
   logic [NSRC-1:0] prev_q;

   for (genvar g = 0; g < NSRC; g++) begin : g_src
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            prev_q[g] <= 1'b0;
         else if (upd_i && src_i == SRC_W'(g))
            prev_q[g] <= level_i;
      end
   end

   assign rise_o = level_i & ~prev_q[src_i];
endmodule

// File: rtl/irq_condition.sv
module irq_condition #(
   parameter int VEC_W = 32,
   localparam int IDX_W = $clog2(VEC_W)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             upd_i,
   input  logic [IDX_W-1:0] idx_i,
   input  logic             rise_i,
   input  logic [VEC_W-1:0] edge_vec_i,
   input  logic [VEC_W-1:0] pol_vec_i,
   output logic             req_o
);
   logic pulse_q;
   logic hold_q;
   logic edge_b;
   logic pol_b;

   assign edge_b = edge_vec_i[idx_i];
   assign pol_b  = pol_vec_i[idx_i];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pulse_q <= 1'b0;
         hold_q  <= 1'b0;
      end else begin
         pulse_q <= upd_i & edge_b & rise_i;
         if (upd_i)
            hold_q <= edge_b ? 1'b0 : pol_b;
      end
   end

   assign req_o = pulse_q | hold_q;
endmodule

// File: rtl/irq_router.sv
module irq_router #(
   parameter int SLOT_W    = 5,
   parameter int PIN_W     = 2,
   parameter int LINE_W    = 8,
   parameter int VEC_W     = 32,
   parameter int LINE_BASE = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              evt_valid_i,
   input  logic [SLOT_W-1:0] evt_slot_i,
   input  logic [PIN_W-1:0]  evt_pin_i,
   input  logic              evt_level_i,
   input  logic [VEC_W-1:0]  edge_sel_i,
   input  logic [VEC_W-1:0]  pol_sel_i,
   output logic [LINE_W-1:0] line_o,
   output logic              irq_req_o
);
   localparam int IDX_W = $clog2(VEC_W);
   localparam int SRC_W = SLOT_W + PIN_W;

   if (SLOT_W < 4) begin : g_bad_slot
      $error("SLOT_W must cover slot 12");
   end
   if (PIN_W < 2) begin : g_bad_pin
      $error("PIN_W must cover four pins");
   end
   if ((1 << IDX_W) != VEC_W) begin : g_bad_vec
      $error("VEC_W must be a power of two");
   end
   if ((1 << LINE_W) <= LINE_BASE + 6 + 4 + (1 << PIN_W)) begin : g_bad_line
      $error("LINE_W too narrow for the highest line");
   end

   logic [LINE_W-1:0] line_d;
   logic [LINE_W-1:0] line_q;
   logic [IDX_W-1:0]  idx;
   logic              rise;

   irq_swizzle #(
      .SLOT_W(SLOT_W), .PIN_W(PIN_W), .LINE_W(LINE_W), .LINE_BASE(LINE_BASE)
   ) u_swz (
      .slot_i(evt_slot_i),
      .pin_i (evt_pin_i),
      .line_o(line_d)
   );

   assign idx = IDX_W'(line_d - LINE_W'(LINE_BASE));

   irq_edge_track #(.SRC_W(SRC_W)) u_trk (
      .clk    (clk),
      .rst_n  (rst_n),
      .upd_i  (evt_valid_i),
      .src_i  ({evt_slot_i, evt_pin_i}),
      .level_i(evt_level_i),
      .rise_o (rise)
   );

   irq_condition #(.VEC_W(VEC_W)) u_cond (
      .clk       (clk),
      .rst_n     (rst_n),
      .upd_i     (evt_valid_i),
      .idx_i     (idx),
      .rise_i    (rise),
      .edge_vec_i(edge_sel_i),
      .pol_vec_i (pol_sel_i),
      .req_o     (irq_req_o)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         line_q <= '0;
      else if (evt_valid_i)
         line_q <= line_d;
   end

   assign line_o = line_q;
endmodule

// File: rtl/irq_router_chk.sv
module irq_router_chk #(
   parameter int SLOT_W    = 5,
   parameter int PIN_W     = 2,
   parameter int LINE_W    = 8,
   parameter int VEC_W     = 32,
   parameter int LINE_BASE = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic              evt_valid_i,
   input logic [SLOT_W-1:0] evt_slot_i,
   input logic [PIN_W-1:0]  evt_pin_i,
   input logic              evt_level_i,
   input logic [VEC_W-1:0]  edge_sel_i,
   input logic [VEC_W-1:0]  pol_sel_i,
   input logic [LINE_W-1:0] line_o,
   input logic              irq_req_o
);
   localparam int IDX_W = $clog2(VEC_W);

   logic [VEC_W-1:0] edge_q;
   logic [VEC_W-1:0] pol_q;
   logic [IDX_W-1:0] cur_idx;

   always_ff @(posedge clk) begin
      edge_q <= edge_sel_i;
      pol_q  <= pol_sel_i;
   end

   assign cur_idx = IDX_W'(line_o - LINE_W'(LINE_BASE));

   p_line_stable_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !evt_valid_i |=> $stable(line_o));

   p_south_map_r2: assert property (@(posedge clk) disable iff (!rst_n)
      evt_valid_i && evt_slot_i == SLOT_W'(5)
      |=> line_o == LINE_W'(LINE_BASE) + LINE_W'($past(evt_pin_i)));

   p_fixed_map_r3: assert property (@(posedge clk) disable iff (!rst_n)
      evt_valid_i && (evt_slot_i == SLOT_W'(6) || evt_slot_i == SLOT_W'(7))
      |=> line_o == LINE_W'(LINE_BASE + 4) + LINE_W'($past(evt_slot_i) == SLOT_W'(7)));

   p_level_req_r9: assert property (@(posedge clk) disable iff (!rst_n)
      $past(evt_valid_i) && !edge_q[cur_idx] |-> irq_req_o == pol_q[cur_idx]);

   p_pulse_width_r7: assert property (@(posedge clk) disable iff (!rst_n)
      irq_req_o && $past(evt_valid_i) && edge_q[cur_idx] && !evt_valid_i |=> !irq_req_o);

   p_no_pulse_low_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $past(evt_valid_i) && !$past(evt_level_i) && edge_q[cur_idx] |-> !irq_req_o);
endmodule

bind irq_router irq_router_chk #(
   .SLOT_W(SLOT_W), .PIN_W(PIN_W), .LINE_W(LINE_W), .VEC_W(VEC_W), .LINE_BASE(LINE_BASE)
) u_chk (.*);

// File: tb/sim_irq_router.sv
`timescale 1ns/1ps
module sim_irq_router;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        evt_valid_i = 1'b0;
   logic [4:0]  evt_slot_i = '0;
   logic [1:0]  evt_pin_i = '0;
   logic        evt_level_i = 1'b0;
   logic [31:0] edge_sel_i = '0;
   logic [31:0] pol_sel_i = '0;
   logic [7:0]  line_o;
   logic        irq_req_o;

   int  n_chk = 0;
   int  n_fail = 0;
   bit  done = 1'b0;
   bit  prev_lvl [0:31][0:3];

   always #2 clk = ~clk;

   irq_router u0 (.*);

   task automatic check(bit ok, string tag, int act, int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   function automatic int exp_line(int s, int p);
      if (s == 5) return 32 + p;
      if (s == 6) return 36;
      if (s == 7) return 37;
      if (s >= 8 && s <= 12) return 38 + (s - 8) + p;
      return p;
   endfunction

   function automatic string line_tag(int s);
      if (s == 5) return "R2";
      if (s == 6 || s == 7) return "R3";
      if (s >= 8 && s <= 12) return "R4";
      return "R5";
   endfunction

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0;
      for (int s = 0; s < 32; s++)
         for (int p = 0; p < 4; p++) prev_lvl[s][p] = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
   endtask

   task automatic evt(int s, int p, bit lvl, string rtag = "");
      int  ln;
      int  ix;
      bit  eb;
      bit  er;
      bit  ei;
      string t;
      @(negedge clk);
      evt_slot_i  = 5'(s);
      evt_pin_i   = 2'(p);
      evt_level_i = lvl;
      evt_valid_i = 1'b1;
      ln = exp_line(s, p);
      ix = (ln - 32) & 31;
      eb = edge_sel_i[ix];
      er = eb ? (lvl && !prev_lvl[s][p]) : pol_sel_i[ix];
      ei = eb ? 1'b0 : pol_sel_i[ix];
      @(negedge clk);
      evt_valid_i = 1'b0;
      check(int'(line_o) == ln, line_tag(s), int'(line_o), ln);
      if (rtag != "") t = rtag;
      else if (!eb) t = "R9";
      else if (er) t = "R7";
      else t = "R8";
      check(irq_req_o == er, t, int'(irq_req_o), int'(er));
      prev_lvl[s][p] = lvl;
      @(negedge clk);
      check(irq_req_o == ei, eb ? "R7" : "R9", int'(irq_req_o), int'(ei));
      check(int'(line_o) == ln, "R6", int'(line_o), ln);
   endtask

   initial begin
      repeat (50000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      logic [7:0] l_sv;
      bit r_sv;
      do_reset();
      @(negedge clk);
      check(line_o == 8'd0, "R1", int'(line_o), 0);
      check(irq_req_o == 1'b0, "R1", int'(irq_req_o), 0);

      // Level-mode sweep over every slot and pin
      edge_sel_i = 32'h0;
      pol_sel_i  = 32'hA5C3_96E1;
      for (int s = 0; s < 32; s++)
         for (int p = 0; p < 4; p++) evt(s, p, bit'((s + p) & 1));

      // Vectors rewritten with no update: the outputs hold
      l_sv = line_o;
      r_sv = irq_req_o;
      pol_sel_i = ~pol_sel_i;
      repeat (3) @(negedge clk);
      check(irq_req_o == r_sv, "R9", int'(irq_req_o), int'(r_sv));
      check(line_o == l_sv, "R6", int'(line_o), int'(l_sv));

      // Edge mode: falling, rising, then steady-high updates
      edge_sel_i = 32'hFFFF_FFFF;
      for (int s = 0; s < 32; s++)
         for (int p = 0; p < 4; p++) evt(s, p, 1'b0);
      for (int s = 0; s < 32; s++)
         for (int p = 0; p < 4; p++) evt(s, p, 1'b1);
      for (int s = 0; s < 32; s++)
         for (int p = 0; p < 4; p++) evt(s, p, 1'b1);

      // Mixed edge and level lines, alternating levels
      edge_sel_i = 32'h5A5A_C3C3;
      pol_sel_i  = 32'h0FF0_9669;
      for (int k = 0; k < 3; k++)
         for (int s = 0; s < 32; s++)
            for (int p = 0; p < 4; p++) evt(s, p, bit'((s + p + k) & 1));

      // Bit selection through the mapped line
      do_reset();
      edge_sel_i = 32'h0;
      pol_sel_i  = 32'h1 << 3;
      evt(0, 3, 1'b1, "R10");
      evt(12, 3, 1'b0, "R10");
      pol_sel_i  = 32'h1 << 13;
      evt(12, 3, 1'b0, "R10");

      // Reset clears the per-source level memory
      evt(9, 2, 1'b1);
      do_reset();
      edge_sel_i = 32'hFFFF_FFFF;
      evt(9, 2, 1'b1, "R11");

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule